// File: doc/BRIEF.md
# FFT Frame and Block Sequencer

This block sits between an input FIFO of host words, a streaming FFT engine and an output FIFO of result words. The host fills the input FIFO with frames of K samples, one 64-bit word per sample. The sequencer unpacks each word into a 16-bit real and a 16-bit imaginary part and passes the samples to the FFT engine at one per clock. It cuts every frame into K/N consecutive, non-overlapping transform blocks and marks the first and last sample of each block. It packs each 32+32-bit result into a 64-bit word for the output FIFO and flags the word that closes a frame.

Both lengths are powers of two and are programmed as base-2 logarithms, together with a transform direction. A configuration write takes effect only while the pipeline is empty, and a write with a bad pair of lengths is refused and raises an error flag. Several frames may be in flight at once: the next frame is read while the results of earlier ones are still coming out of the engine.

Back-pressure works as follows. On the input side, `in_valid`/`in_ready` form a standard valid/ready handshake, and `in_ready` can be high only while the engine's `core_in_ready` is high. The engine's result stream has no stall, so the output side runs on credit instead of a ready signal. The sequencer holds back the first sample of a block until the output FIFO's reported free space covers every result still owed plus a whole block. Two running counters report finished frames and finished blocks.

Top module: `fftc_frame_ctrl`

## Requirements
- R1: After reset the configuration is frame exponent 10, transform exponent 10, forward direction. A write (`cfg_wr` high for one cycle) that is accepted shows up on `stat_frame_lg`, `stat_fft_lg`, `stat_inverse`, `core_fft_lg` and `core_inverse` from the next cycle.
- R2: A write made while idle is accepted only if the frame exponent lies in 10..16, the transform exponent lies in 5..16, and the transform exponent is not above the frame exponent, so that N divides K. An idle write that fails these tests leaves the configuration as it was and sets `stat_cfg_err`. An accepted write clears `stat_cfg_err`.
- R3: `stat_busy` is high while a frame has been partly read, while any accepted sample still has no written result, or while a sample is being offered to the engine. A write made while busy changes neither the configuration nor `stat_cfg_err`.
- R4: `core_in_re` is `in_data[15:0]` and `core_in_im` is `in_data[31:16]`. Bits 63:32 are ignored. `core_in_valid` is high only with `in_valid`, and `in_ready` is high only with `core_in_ready`. A sample reaches the engine in the same cycle as its input handshake.
- R5: `core_in_sop` is high on the first sample of every N-sample block and `core_in_eop` on the last, with blocks counted over accepted samples only.
- R6: Each cycle in which `core_out_valid` is high produces an `out_valid` word one cycle later. That word holds the real part in bits 31:0 and the imaginary part in bits 63:32, and results leave in arrival order.
- R7: `out_last` is high exactly on the output word that is the K-th result of its frame.
- R8: The first sample of a block is accepted only when `out_free` is at least N plus the number of accepted samples whose results are not yet written. Inside a block, input is never held back for space. No output word is written into a full FIFO.
- R9: `stat_frames_done` rises by one in the cycle after each `out_last` word. `stat_blocks_done` rises by one in the cycle after each N-th result word of a block.
- R10: The first sample of a new frame can be accepted while results of earlier frames are still outstanding.
- R11: During and right after reset, `stat_busy`, `stat_cfg_err`, `out_valid` and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_frame_lg | input | 5 | Frame length exponent to write (K = 2^value) |
| cfg_fft_lg | input | 5 | Transform length exponent to write (N = 2^value) |
| cfg_inverse | input | 1 | Direction to write, 1 = inverse |
| stat_frame_lg | output | 5 | Current frame length exponent |
| stat_fft_lg | output | 5 | Current transform length exponent |
| stat_inverse | output | 1 | Current direction |
| stat_busy | output | 1 | Pipeline not empty |
| stat_cfg_err | output | 1 | Last idle write was refused |
| stat_frames_done | output | 16 | Frames fully written out (wraps) |
| stat_blocks_done | output | 16 | Blocks fully written out (wraps) |
| in_valid | input | 1 | Input FIFO has a word |
| in_ready | output | 1 | Word taken this cycle when valid |
| in_data | input | 64 | Input word |
| core_in_valid | output | 1 | Sample offered to engine |
| core_in_ready | input | 1 | Engine accepts a sample |
| core_in_re | output | 16 | Sample real part |
| core_in_im | output | 16 | Sample imaginary part |
| core_in_sop | output | 1 | First sample of a block |
| core_in_eop | output | 1 | Last sample of a block |
| core_fft_lg | output | 5 | Transform length exponent for the engine |
| core_inverse | output | 1 | Direction for the engine |
| core_out_valid | input | 1 | Engine result present |
| core_out_re | input | 32 | Result real part |
| core_out_im | input | 32 | Result imaginary part |
| out_valid | output | 1 | Write strobe to output FIFO |
| out_data | output | 64 | Packed result word |
| out_last | output | 1 | Word closes a frame |
| out_free | input | 18 | Free words in the output FIFO |

## Verification
The hardest case to reach is the space gate at a block boundary with more than one frame in flight. It needs a nearly full output FIFO, a stalling engine and an input that never runs dry, all at once. The bench reaches it with a 3000-word output FIFO that it drains on about one cycle in eight, a randomly stalling engine, and three back-to-back 2048-sample frames split into 256-sample blocks. Under those conditions the gate closes repeatedly and later frames enter while earlier results are still in the engine. The bench counts both events and checks that each one actually occurred.

// File: rtl/fftc_pkg.sv
package fftc_pkg;
  localparam int LG_W = 5;

  typedef logic [LG_W-1:0] lg_t;

  typedef struct packed {
    lg_t  frame_lg;
    lg_t  fft_lg;
    logic inverse;
  } fftc_cfg_t;

  // length from exponent, wide enough for any legal exponent
  function automatic logic [31:0] pow2(input lg_t lg);
    return 32'd1 << lg;
  endfunction
endpackage

// File: rtl/fftc_cfg_regs.sv
module fftc_cfg_regs
  import fftc_pkg::*;
#(
  parameter int MIN_FRAME_LG = 10,
  parameter int MAX_FRAME_LG = 16,
  parameter int MIN_FFT_LG   = 5,
  parameter int MAX_FFT_LG   = 16,
  parameter int DEF_FRAME_LG = 10,
  parameter int DEF_FFT_LG   = 10
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  fftc_cfg_t wr_cfg,
  input  logic      busy,
  output fftc_cfg_t cfg,
  output logic      err
);
  localparam lg_t FR_LO = lg_t'(MIN_FRAME_LG);
  localparam lg_t FR_HI = lg_t'(MAX_FRAME_LG);
  localparam lg_t FT_LO = lg_t'(MIN_FFT_LG);
  localparam lg_t FT_HI = lg_t'(MAX_FFT_LG);

  logic legal;

  always_comb begin
    legal = (wr_cfg.frame_lg >= FR_LO) && (wr_cfg.frame_lg <= FR_HI) &&
            (wr_cfg.fft_lg   >= FT_LO) && (wr_cfg.fft_lg   <= FT_HI) &&
            (wr_cfg.fft_lg   <= wr_cfg.frame_lg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.frame_lg <= lg_t'(DEF_FRAME_LG);
      cfg.fft_lg   <= lg_t'(DEF_FFT_LG);
      cfg.inverse  <= 1'b0;
      err          <= 1'b0;
    end else if (wr_en && !busy) begin
      if (legal) begin
        cfg <= wr_cfg;
        err <= 1'b0;
      end else begin
        err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fftc_in_seq.sv
module fftc_in_seq
  import fftc_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int OCC_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lg_t              frame_lg,
  input  lg_t              fft_lg,
  input  logic             in_valid,
  input  logic [31:0]      in_word,
  output logic             in_ready,
  input  logic             core_in_ready,
  output logic             core_in_valid,
  output logic [15:0]      core_in_re,
  output logic [15:0]      core_in_im,
  output logic             core_in_sop,
  output logic             core_in_eop,
  input  logic [OCC_W-1:0] out_free,
  input  logic [OCC_W-1:0] owed,
  output logic             fire,
  output logic             mid_frame
);
  typedef logic [POS_W:0] len_t;
  typedef logic [OCC_W:0] occ_t;

  logic [POS_W-1:0] blk_pos, frm_pos;
  len_t blk_len, frm_len;
  logic blk_last, frm_last;
  occ_t need;
  logic gate;

  always_comb begin
    blk_len  = len_t'(pow2(fft_lg));
    frm_len  = len_t'(pow2(frame_lg));
    blk_last = ({1'b0, blk_pos} == blk_len - len_t'(1));
    frm_last = ({1'b0, frm_pos} == frm_len - len_t'(1));
    need     = {1'b0, owed} + occ_t'(blk_len);
    // a block may only start when its whole result fits behind what is owed
    gate     = (blk_pos != '0) || ({1'b0, out_free} >= need);
  end

  assign core_in_valid = in_valid && gate;
  assign in_ready      = core_in_ready && gate;
  assign fire          = in_valid && in_ready;
  assign core_in_re    = in_word[15:0];
  assign core_in_im    = in_word[31:16];
  assign core_in_sop   = (blk_pos == '0);
  assign core_in_eop   = blk_last;
  assign mid_frame     = (frm_pos != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_pos <= '0;
      frm_pos <= '0;
    end else if (fire) begin
      blk_pos <= blk_last ? '0 : blk_pos + 1'b1;
      frm_pos <= frm_last ? '0 : frm_pos + 1'b1;
    end
  end
endmodule

// File: rtl/fftc_out_pack.sv
module fftc_out_pack
  import fftc_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lg_t              frame_lg,
  input  lg_t              fft_lg,
  input  logic             core_out_valid,
  input  logic [31:0]      core_out_re,
  input  logic [31:0]      core_out_im,
  output logic             out_valid,
  output logic [63:0]      out_data,
  output logic             out_last,
  output logic [CNT_W-1:0] frames_done,
  output logic [CNT_W-1:0] blocks_done
);
  typedef logic [POS_W:0] len_t;

  logic [POS_W-1:0] blk_pos, frm_pos;
  logic blk_last, frm_last, blk_end_q;

  always_comb begin
    blk_last = ({1'b0, blk_pos} == len_t'(pow2(fft_lg))   - len_t'(1));
    frm_last = ({1'b0, frm_pos} == len_t'(pow2(frame_lg)) - len_t'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      blk_end_q <= 1'b0;
      blk_pos   <= '0;
      frm_pos   <= '0;
    end else begin
      out_valid <= core_out_valid;
      if (core_out_valid) begin
        out_data  <= {core_out_im, core_out_re};
        out_last  <= frm_last;
        blk_end_q <= blk_last;
        blk_pos   <= blk_last ? '0 : blk_pos + 1'b1;
        frm_pos   <= frm_last ? '0 : frm_pos + 1'b1;
      end else begin
        out_last  <= 1'b0;
        blk_end_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frames_done <= '0;
      blocks_done <= '0;
    end else begin
      if (out_valid && out_last)  frames_done <= frames_done + 1'b1;
      if (out_valid && blk_end_q) blocks_done <= blocks_done + 1'b1;
    end
  end
endmodule

// File: rtl/fftc_frame_ctrl.sv
module fftc_frame_ctrl
  import fftc_pkg::*;
#(
  parameter int MIN_FRAME_LG = 10,
  parameter int MAX_FRAME_LG = 16,
  parameter int MIN_FFT_LG   = 5,
  parameter int MAX_FFT_LG   = 16,
  parameter int DEF_FRAME_LG = 10,
  parameter int DEF_FFT_LG   = 10,
  parameter int OCC_W        = 18,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [LG_W-1:0]  cfg_frame_lg,
  input  logic [LG_W-1:0]  cfg_fft_lg,
  input  logic             cfg_inverse,
  output logic [LG_W-1:0]  stat_frame_lg,
  output logic [LG_W-1:0]  stat_fft_lg,
  output logic             stat_inverse,
  output logic             stat_busy,
  output logic             stat_cfg_err,
  output logic [CNT_W-1:0] stat_frames_done,
  output logic [CNT_W-1:0] stat_blocks_done,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [63:0]      in_data,
  output logic             core_in_valid,
  input  logic             core_in_ready,
  output logic [15:0]      core_in_re,
  output logic [15:0]      core_in_im,
  output logic             core_in_sop,
  output logic             core_in_eop,
  output logic [LG_W-1:0]  core_fft_lg,
  output logic             core_inverse,
  input  logic             core_out_valid,
  input  logic [31:0]      core_out_re,
  input  logic [31:0]      core_out_im,
  output logic             out_valid,
  output logic [63:0]      out_data,
  output logic             out_last,
  input  logic [OCC_W-1:0] out_free
);
  localparam int POS_W = MAX_FRAME_LG;

  fftc_cfg_t cfg, wr_cfg;
  logic fire, mid_frame, busy;
  logic [OCC_W-1:0] owed;
  logic unused_hi;

  assign unused_hi = ^in_data[63:32];
  assign wr_cfg    = '{frame_lg: cfg_frame_lg, fft_lg: cfg_fft_lg, inverse: cfg_inverse};

  fftc_cfg_regs #(
    .MIN_FRAME_LG(MIN_FRAME_LG), .MAX_FRAME_LG(MAX_FRAME_LG),
    .MIN_FFT_LG(MIN_FFT_LG),     .MAX_FFT_LG(MAX_FFT_LG),
    .DEF_FRAME_LG(DEF_FRAME_LG), .DEF_FFT_LG(DEF_FFT_LG)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_cfg(wr_cfg),
    .busy(busy), .cfg(cfg), .err(stat_cfg_err)
  );

  fftc_in_seq #(.POS_W(POS_W), .OCC_W(OCC_W)) u_in (
    .clk(clk), .rst_n(rst_n),
    .frame_lg(cfg.frame_lg), .fft_lg(cfg.fft_lg),
    .in_valid(in_valid), .in_word(in_data[31:0]), .in_ready(in_ready),
    .core_in_ready(core_in_ready), .core_in_valid(core_in_valid),
    .core_in_re(core_in_re), .core_in_im(core_in_im),
    .core_in_sop(core_in_sop), .core_in_eop(core_in_eop),
    .out_free(out_free), .owed(owed), .fire(fire), .mid_frame(mid_frame)
  );

  fftc_out_pack #(.POS_W(POS_W), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .frame_lg(cfg.frame_lg), .fft_lg(cfg.fft_lg),
    .core_out_valid(core_out_valid), .core_out_re(core_out_re),
    .core_out_im(core_out_im), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .frames_done(stat_frames_done),
    .blocks_done(stat_blocks_done)
  );

  // results owed: samples handed to the engine but not yet written out
  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else if (fire && !out_valid) owed <= owed + 1'b1;
    else if (!fire && out_valid) owed <= owed - 1'b1;
  end

  assign busy          = (owed != '0) || mid_frame || core_in_valid;
  assign stat_busy     = busy;
  assign stat_frame_lg = cfg.frame_lg;
  assign stat_fft_lg   = cfg.fft_lg;
  assign stat_inverse  = cfg.inverse;
  assign core_fft_lg   = cfg.fft_lg;
  assign core_inverse  = cfg.inverse;
endmodule

// File: rtl/fftc_frame_ctrl_chk.sv
module fftc_frame_ctrl_chk
  import fftc_pkg::*;
#(
  parameter int OCC_W = 18,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [LG_W-1:0]  stat_frame_lg,
  input logic [LG_W-1:0]  stat_fft_lg,
  input logic             stat_inverse,
  input logic             stat_busy,
  input logic             stat_cfg_err,
  input logic [CNT_W-1:0] stat_frames_done,
  input logic             in_valid,
  input logic             in_ready,
  input logic             core_in_valid,
  input logic             core_in_ready,
  input logic             core_in_sop,
  input logic             core_in_eop,
  input logic             out_valid,
  input logic             out_last,
  input logic [OCC_W-1:0] out_free
);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_free != '0);

  a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stat_busy |=> $stable({stat_frame_lg, stat_fft_lg, stat_inverse}));

  a_r2_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_cfg_err) |-> $past(cfg_wr));

  a_r4_ready_needs_core: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> core_in_ready);

  a_r4_offer_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    core_in_valid |-> in_valid);

  a_r5_marks_apart: assert property (@(posedge clk) disable iff (!rst_n)
    core_in_valid |-> !(core_in_sop && core_in_eop));

  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r9_done_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_frames_done) |-> $past(out_valid && out_last));
endmodule

bind fftc_frame_ctrl fftc_frame_ctrl_chk #(.OCC_W(OCC_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/fftc_frame_ctrl_test.sv
module fftc_frame_ctrl_test;
  import fftc_pkg::*;

  localparam int CLK_NS = 10;
  localparam int OCC_W  = 18;
  localparam int CNT_W  = 16;
  localparam int CAP    = 3000;
  localparam int LAT    = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_inverse = 1'b0;
  logic [LG_W-1:0] cfg_frame_lg = '0, cfg_fft_lg = '0;
  logic [LG_W-1:0] stat_frame_lg, stat_fft_lg, core_fft_lg;
  logic stat_inverse, stat_busy, stat_cfg_err, core_inverse;
  logic [CNT_W-1:0] stat_frames_done, stat_blocks_done;
  logic in_valid = 1'b0, in_ready;
  logic [63:0] in_data = '0;
  logic core_in_valid, core_in_ready, core_in_sop, core_in_eop;
  logic [15:0] core_in_re, core_in_im;
  logic core_out_valid;
  logic [31:0] core_out_re, core_out_im;
  logic out_valid, out_last;
  logic [63:0] out_data;
  logic [OCC_W-1:0] out_free;

  fftc_frame_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_frame_lg(cfg_frame_lg),
    .cfg_fft_lg(cfg_fft_lg), .cfg_inverse(cfg_inverse),
    .stat_frame_lg(stat_frame_lg), .stat_fft_lg(stat_fft_lg),
    .stat_inverse(stat_inverse), .stat_busy(stat_busy),
    .stat_cfg_err(stat_cfg_err), .stat_frames_done(stat_frames_done),
    .stat_blocks_done(stat_blocks_done), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .core_in_valid(core_in_valid),
    .core_in_ready(core_in_ready), .core_in_re(core_in_re),
    .core_in_im(core_in_im), .core_in_sop(core_in_sop),
    .core_in_eop(core_in_eop), .core_fft_lg(core_fft_lg),
    .core_inverse(core_inverse), .core_out_valid(core_out_valid),
    .core_out_re(core_out_re), .core_out_im(core_out_im),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_free(out_free)
  );

  always #(CLK_NS/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit slow_drain = 1'b0, core_stall = 1'b0, model_on = 1'b0, drain = 1'b0;
  int fifo_cnt;

  task automatic check(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // engine stand-in: fixed latency, sign extension, imaginary inverted when inverse
  logic v_pipe [LAT];
  logic [31:0] re_pipe [LAT], im_pipe [LAT];
  always @(posedge clk) begin
    for (int i = 0; i < LAT; i++) begin
      if (!rst_n) v_pipe[i] <= 1'b0;
      else if (i == 0) v_pipe[0] <= core_in_valid && core_in_ready;
      else v_pipe[i] <= v_pipe[i-1];
      if (i == 0) begin
        re_pipe[0] <= sx(core_in_re);
        im_pipe[0] <= sx(core_in_im) ^ {32{core_inverse}};
      end else begin
        re_pipe[i] <= re_pipe[i-1];
        im_pipe[i] <= im_pipe[i-1];
      end
    end
  end
  assign core_out_valid = v_pipe[LAT-1];
  assign core_out_re    = re_pipe[LAT-1];
  assign core_out_im    = im_pipe[LAT-1];

  // output FIFO stand-in
  always @(posedge clk) begin
    if (!rst_n) fifo_cnt <= 0;
    else fifo_cnt <= fifo_cnt + (out_valid ? 1 : 0) - ((drain && fifo_cnt > 0) ? 1 : 0);
  end
  assign out_free = OCC_W'(CAP - fifo_cnt);

  always @(posedge clk) begin
    #1;
    core_in_ready = core_stall ? ($urandom_range(3) != 0) : 1'b1;
    drain         = slow_drain ? ($urandom_range(7) == 0) : 1'b1;
  end

  // reference model
  int m_frame_lg = 10, m_fft_lg = 10, m_inv = 0, m_err = 0;
  int m_in_frame = 0, m_in_blk = 0, m_issued = 0, m_written = 0;
  int m_out_blk = 0, m_frames = 0, m_blocks = 0;
  int stall_seen = 0, overlap_seen = 0;
  logic [63:0] exp_data [$];
  bit exp_last [$];

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      int k, n, outst, freev;
      bit gate, cval, busy_e, fire, legal;
      logic [63:0] ed;
      bit el;
      k = 1 << m_frame_lg;
      n = 1 << m_fft_lg;
      outst = m_issued - m_written;
      freev = CAP - fifo_cnt;
      gate  = (m_in_blk != 0) || (freev >= outst + n);
      cval  = in_valid && gate;
      busy_e = (outst != 0) || (m_in_frame != 0) || cval;

      check("R1", "frame exponent", stat_frame_lg, m_frame_lg);
      check("R1", "fft exponent", stat_fft_lg, m_fft_lg);
      check("R1", "core fft exponent", core_fft_lg, m_fft_lg);
      check("R1", "direction", stat_inverse, m_inv);
      check("R2", "cfg error", stat_cfg_err, m_err);
      check("R3", "busy", stat_busy, busy_e);
      check("R8", "core_in_valid gate", core_in_valid, cval);
      check("R8", "in_ready gate", in_ready, core_in_ready && gate);
      if (in_valid && core_in_ready && !gate) stall_seen++;

      fire = in_valid && in_ready;
      if (fire) begin
        check("R4", "real part", core_in_re, in_data[15:0]);
        check("R4", "imag part", core_in_im, in_data[31:16]);
        check("R5", "block start", core_in_sop, m_in_blk == 0);
        check("R5", "block end", core_in_eop, m_in_blk == n - 1);
        if (m_in_frame == 0 && outst != 0) overlap_seen++;
        exp_data.push_back({sx(in_data[31:16]) ^ {32{m_inv[0]}}, sx(in_data[15:0])});
        exp_last.push_back(m_in_frame == k - 1);
        m_in_blk   = (m_in_blk == n - 1) ? 0 : m_in_blk + 1;
        m_in_frame = (m_in_frame == k - 1) ? 0 : m_in_frame + 1;
        m_issued++;
      end

      check("R9", "frames done", stat_frames_done, m_frames);
      check("R9", "blocks done", stat_blocks_done, m_blocks);

      if (out_valid) begin
        check("R8", "fifo room at write", fifo_cnt < CAP, 1);
        if (exp_data.size() == 0) begin
          check("R6", "unexpected output word", 1, 0);
        end else begin
          ed = exp_data.pop_front();
          el = exp_last.pop_front();
          check("R6", "packed result", out_data, ed);
          check("R7", "frame end flag", out_last, el);
          if (el) m_frames++;
        end
        if (m_out_blk == n - 1) begin m_blocks++; m_out_blk = 0; end
        else m_out_blk++;
        m_written++;
      end else begin
        check("R7", "last without valid", out_last, 0);
      end

      if (cfg_wr && !busy_e) begin
        legal = (cfg_frame_lg >= 10) && (cfg_frame_lg <= 16) &&
                (cfg_fft_lg >= 5) && (cfg_fft_lg <= 16) && (cfg_fft_lg <= cfg_frame_lg);
        if (legal) begin
          m_frame_lg = int'(cfg_frame_lg);
          m_fft_lg   = int'(cfg_fft_lg);
          m_inv      = int'(cfg_inverse);
          m_err      = 0;
        end else begin
          m_err = 1;
        end
      end
    end
  end

  task automatic cfg_write(int f, int n, bit inv);
    cfg_wr = 1'b1;
    cfg_frame_lg = LG_W'(f);
    cfg_fft_lg = LG_W'(n);
    cfg_inverse = inv;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic send(int words, bit gappy);
    for (int i = 0; i < words; i++) begin
      bit acc;
      if (gappy && $urandom_range(2) == 0) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_data  = {$urandom, $urandom};
      in_valid = 1'b1;
      forever begin
        @(negedge clk);
        acc = in_ready;
        @(posedge clk); #1;
        if (acc) break;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    slow_drain = 1'b0;
    forever begin
      @(negedge clk);
      if (!stat_busy && fifo_cnt == 0) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R11", "reset busy", stat_busy, 0);
    check("R11", "reset err", stat_cfg_err, 0);
    check("R11", "reset out_valid", out_valid, 0);
    check("R11", "reset frames", stat_frames_done, 0);
    check("R11", "reset blocks", stat_blocks_done, 0);
    check("R1", "reset frame exponent", stat_frame_lg, 10);
    check("R1", "reset fft exponent", stat_fft_lg, 10);
    @(posedge clk); #1;
    rst_n = 1'b1;
    model_on = 1'b1;
    @(posedge clk); #1;

    // K=1024, N=32, forward; a write in mid-stream must be ignored
    cfg_write(10, 5, 1'b0);
    check("R1", "accepted fft exponent", stat_fft_lg, 5);
    fork
      send(2048, 1'b0);
      begin repeat (100) @(posedge clk); #1; cfg_write(11, 8, 1'b1); end
    join
    check("R3", "write while busy ignored", stat_fft_lg, 5);
    wait_idle();
    check("R9", "two frames done", stat_frames_done, 2);

    // refused writes
    cfg_write(10, 11, 1'b0);
    check("R2", "N above K refused", stat_cfg_err, 1);
    check("R2", "config kept", stat_fft_lg, 5);
    cfg_write(9, 5, 1'b0);
    check("R2", "short frame refused", stat_frame_lg, 10);
    cfg_write(11, 8, 1'b1);
    check("R2", "error cleared", stat_cfg_err, 0);

    // K=2048, N=256, inverse, tight output space and stalling engine
    slow_drain = 1'b1;
    core_stall = 1'b1;
    send(3 * 2048, 1'b0);
    wait_idle();
    check("R8", "space stall reached", stall_seen > 0, 1);
    check("R10", "frame entered with results owed", overlap_seen > 0, 1);

    // K=N=1024, gappy input
    cfg_write(10, 10, 1'b0);
    send(2048, 1'b1);
    wait_idle();
    core_stall = 1'b0;

    check("R6", "all results delivered", exp_data.size(), 0);
    check("R9", "total frames", stat_frames_done, 7);
    check("R9", "total blocks", stat_blocks_done, 90);
    finish_run();
  end
endmodule